// File: doc/BRIEF.md
# Multi-supply reset timeout sequencer

This block merges four digital undervoltage flags, an active-low manual reset line and a watchdog overflow strobe into one system reset. Any supply flag or a manual reset that survives its glitch filter forces the reset on. The reset is released only after a selectable timeout has run out with every source quiet. A watchdog overflow does not hold the reset as a level. It starts one reset pulse of exactly one timeout period.

The timeout is counted in millisecond ticks from an internal prescaler built from the clock-frequency parameter. A scale parameter shortens the tick so that a simulation can cover all four timeouts quickly. A parameter sets the polarity of the reset output. A separate active-high busy bit tells a companion watchdog that reset is in force, so it can clear its own timer.

Top module: `rst_seq_top`

## Requirements
- R1: A supply flag at 1 (supply below threshold) on any of `uv_flag[3:0]` forces `rst_busy` high within 3 clock edges, and holds it high for as long as the flag stays high.
- R2: A low level on `mr_n` lasting at least F clock cycles forces `rst_busy` high, where F = ceil(CLK_HZ * MR_FILT_NS / 1e9), with a minimum of 1. With CLK_HZ = 8 MHz and MR_FILT_NS = 500, F is 4.
- R3: A low pulse on `mr_n` shorter than F cycles has no effect: `rst_busy` stays low.
- R4: After the last fault goes away, `rst_busy` falls exactly 2 + T cycles after a supply flag falls, or exactly 3 + T cycles after `mr_n` returns high. T = ticks * C, where C = CLK_HZ / (1000 * TICK_SCALE) is the number of cycles per tick.
- R5: `tmo_sel` picks the timeout in ticks as TMO_BASE << tmo_sel: code 0 gives 50, 1 gives 100, 2 gives 200 and 3 gives 400 (ms at TICK_SCALE = 1).
- R6: A one-cycle `wd_ovf` pulse while `rst_busy` is low sets `rst_busy` at the next edge and releases it exactly 1 + T edges after the pulse was driven. A `wd_ovf` pulse while `rst_busy` is already high leaves the release time unchanged.
- R7: With ACT_HIGH = 0, `sys_rst` is the inverse of `rst_busy`. With ACT_HIGH = 1, `sys_rst` equals `rst_busy`.
- R8: `rst_busy` is high during reset. After reset ends with all sources quiet, it falls exactly 2 + T edges later.
- R9: A fault that comes back while the timeout is counting restarts the full period. A one-cycle supply flag pulse leads to release 3 + T edges after its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| uv_flag | input | NUM_SUP | Asynchronous undervoltage flags, 1 = supply below threshold |
| mr_n | input | 1 | Asynchronous manual reset, active low |
| wd_ovf | input | 1 | Watchdog overflow strobe, one cycle, synchronous to clk |
| tmo_sel | input | 2 | Timeout code, 0..3 = 1x, 2x, 4x, 8x of TMO_BASE ticks |
| sys_rst | output | 1 | Stretched reset output, polarity chosen by ACT_HIGH |
| rst_busy | output | 1 | Active-high reset-in-force status for the watchdog |

## Verification
The assertions assume that `wd_ovf` is a pulse synchronous to the clock. They also assume that `tmo_sel` holds steady for the whole of any countdown, because changing the code mid-count has no defined release point. The flags and `mr_n` may change at any time, since they pass through the synchronizer. The stimulus changes `tmo_sel` only while no countdown is running. It drives `wd_ovf` for exactly one cycle, and it changes every input on the falling clock edge, so the synchronizer latency behind each expected cycle count is fixed.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        TMO_1X = 2'd0,
        TMO_2X = 2'd1,
        TMO_4X = 2'd2,
        TMO_8X = 2'd3
    } tmo_code_e;

    // Timeout length in ticks for a code: base doubled per code step.
    function automatic int unsigned tmo_ticks(tmo_code_e code, int unsigned base);
        return base << code;
    endfunction

    // Integer quotient, never below one.
    function automatic int unsigned div_min1(int unsigned num, int unsigned den);
        int unsigned q;
        q = num / den;
        return (q == 0) ? 1 : q;
    endfunction

    // Cycles covering a time in ns, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(int unsigned hz, int unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(hz) * longint'(ns);
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        return (cyc == 0) ? 1 : int'(cyc);
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Two flops per bit; reset value all ones (supplies bad, manual reset idle).
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/rst_seq_prescale.sv
module rst_seq_prescale #(
    parameter int unsigned CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC - 1);

    logic [PW-1:0] pre;

    assign tick = (pre == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
        end else if (tick) begin
            pre <= '0;
        end else begin
            pre <= pre + PW'(1);
        end
    end

    // Two ticks never come back to back unless a tick lasts one cycle.
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && CYC > 1) |=> !tick); // R4

endmodule

// File: rtl/rst_seq_mrfilt.sv
module rst_seq_mrfilt #(
    parameter int unsigned FILT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic low,
    output logic act
);
    localparam int FW = $clog2(FILT + 1);
    localparam logic [FW-1:0] FMAX = FW'(FILT);

    logic [FW-1:0] run;

    assign act = (run == FMAX);

    always_ff @(posedge clk) begin
        if (rst || !low) begin
            run <= '0;
        end else if (!act) begin
            run <= run + FW'(1);
        end
    end

    AST_MR_GLITCH_DROP: assert property (@(posedge clk) disable iff (rst)
        !low |=> !act); // R3

    AST_MR_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(act) |-> $past(low)); // R2

endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer
    import rst_seq_pkg::*;
#(
    parameter int unsigned BASE  = 50,
    parameter int          CNT_W = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fault,
    input  logic       wd_ovf,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       load,
    output logic       act
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tstate_t;

    tstate_t          st;
    logic [CNT_W-1:0] lim_m1;
    logic             wd_start;

    assign lim_m1   = CNT_W'(tmo_ticks(tmo_code_e'(sel), BASE) - 1);
    assign wd_start = wd_ovf && !st.busy;
    assign load     = fault || wd_start;
    assign act      = st.busy;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            st.busy <= 1'b1;
            st.cnt  <= '0;
        end else if (st.busy && tick) begin
            if (st.cnt >= lim_m1) begin
                st.busy <= 1'b0;
                st.cnt  <= '0;
            end else begin
                st.cnt  <= st.cnt + CNT_W'(1);
            end
        end
    end

    AST_FAULT_FORCES_RESET: assert property (@(posedge clk) disable iff (rst)
        fault |=> act); // R1

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(act) |-> $past(tick)); // R4

    AST_NO_RELEASE_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
        $fell(act) |-> !$past(fault)); // R9

    AST_WD_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        (wd_ovf && !act && !fault) |=> (act && st.cnt == '0)); // R6

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int          NUM_SUP    = 4,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TICK_SCALE = 1,
    parameter int unsigned MR_FILT_NS = 500,
    parameter int unsigned TMO_BASE   = 50,
    parameter bit          ACT_HIGH   = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SUP-1:0] uv_flag,
    input  logic               mr_n,
    input  logic               wd_ovf,
    input  logic [1:0]         tmo_sel,
    output logic               sys_rst,
    output logic               rst_busy
);
    localparam int unsigned CYC_PER_TICK = div_min1(CLK_HZ, 1000 * TICK_SCALE);
    localparam int unsigned MR_FILT_CYC  = ns_to_cycles(CLK_HZ, MR_FILT_NS);
    localparam int unsigned MAX_TICKS    = TMO_BASE << 3;
    localparam int          CNT_W        = $clog2(MAX_TICKS);
    localparam int          SYNC_W       = NUM_SUP + 1;

    logic [SYNC_W-1:0]  async_in;
    logic [SYNC_W-1:0]  sync_out;
    logic [NUM_SUP-1:0] uv_s;
    logic               mr_low_s;
    logic               mr_act;
    logic               fault;
    logic               load;
    logic               tick;
    logic               busy;

    assign async_in = {mr_n, uv_flag};
    assign uv_s     = sync_out[NUM_SUP-1:0];
    assign mr_low_s = ~sync_out[NUM_SUP];
    assign fault    = (|uv_s) || mr_act;

    rst_seq_sync #(
        .WIDTH (SYNC_W)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_in),
        .q   (sync_out)
    );

    rst_seq_mrfilt #(
        .FILT (MR_FILT_CYC)
    ) u_mrfilt (
        .clk (clk),
        .rst (rst),
        .low (mr_low_s),
        .act (mr_act)
    );

    rst_seq_prescale #(
        .CYC (CYC_PER_TICK)
    ) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .clr  (load),
        .tick (tick)
    );

    rst_seq_timer #(
        .BASE  (TMO_BASE),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .fault  (fault),
        .wd_ovf (wd_ovf),
        .tick   (tick),
        .sel    (tmo_sel),
        .load   (load),
        .act    (busy)
    );

    assign rst_busy = busy;

    generate
        if (ACT_HIGH) begin : g_out_high
            assign sys_rst = busy;
        end else begin : g_out_low
            assign sys_rst = ~busy;
        end
    endgenerate

    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (|uv_s) |=> rst_busy); // R1

endmodule

// File: tb/rst_seq_top_bench.sv
module rst_seq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CYC  = 4;   // 8 MHz / (1000 * 2000)
    localparam int FILT = 4;   // ceil(8 MHz * 500 ns)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] uv_flag = 4'b0;
    logic       mr_n = 1'b1;
    logic       wd_ovf = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic       sys_rst_lo, sys_rst_hi, busy_lo, busy_hi;

    int total = 0;
    int bad = 0;
    int pol_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_top #(.CLK_HZ(8_000_000), .TICK_SCALE(2000), .MR_FILT_NS(500), .ACT_HIGH(1'b0))
    u_rst_seq_top (.clk(clk), .rst(rst), .uv_flag(uv_flag), .mr_n(mr_n), .wd_ovf(wd_ovf),
                   .tmo_sel(tmo_sel), .sys_rst(sys_rst_lo), .rst_busy(busy_lo));

    rst_seq_top #(.CLK_HZ(8_000_000), .TICK_SCALE(2000), .MR_FILT_NS(500), .ACT_HIGH(1'b1))
    u_rst_seq_top_hi (.clk(clk), .rst(rst), .uv_flag(uv_flag), .mr_n(mr_n), .wd_ovf(wd_ovf),
                      .tmo_sel(tmo_sel), .sys_rst(sys_rst_hi), .rst_busy(busy_hi));

    // {sel[1:0], src[2:0]}; src 0..3 = supply flag, 4 = manual, 5 = watchdog
    localparam bit [4:0] VEC [8] = '{
        {2'd0, 3'd0}, {2'd1, 3'd1}, {2'd2, 3'd2}, {2'd3, 3'd3},
        {2'd0, 3'd4}, {2'd3, 3'd4}, {2'd1, 3'd5}, {2'd2, 3'd5}
    };

    function automatic int tmo_cycles(input logic [1:0] s);
        return (50 << s) * CYC;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample_pol();
        if (sys_rst_lo !== ~busy_lo || sys_rst_hi !== busy_lo || busy_hi !== busy_lo)
            pol_bad++;
    endtask

    // Counts posedges until busy is seen high and then low; start = edges already spent.
    task automatic count_release(input int start, output int n);
        bit seen;
        seen = busy_lo;
        n = start;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk); #1;
            n++;
            sample_pol();
            if (busy_lo) seen = 1'b1;
            else if (seen) return;
        end
        n = -1;
    endtask

    initial begin
        int n;
        bit stayed;
        repeat (5) @(posedge clk);
        #1;
        chk(busy_lo == 1'b1, "R8 busy in reset", busy_lo, 1);
        chk(sys_rst_lo == 1'b0 && sys_rst_hi == 1'b1, "R7 polarity in reset",
            {sys_rst_hi, sys_rst_lo}, 2'b10);
        @(negedge clk); rst = 1'b0;
        count_release(0, n);
        chk(n == 2 + tmo_cycles(2'd0), "R8 power-up release", n, 2 + tmo_cycles(2'd0));

        // Table walk: R1 R2 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            logic [1:0] s;
            int src;
            int exp;
            s = VEC[v][4:3];
            src = int'(VEC[v][2:0]);
            @(negedge clk); tmo_sel = s;
            repeat (5) @(negedge clk);
            if (src < 4) begin
                uv_flag[src] = 1'b1;
                repeat (12) @(negedge clk);
                chk(busy_lo == 1'b1, "R1 supply flag forces reset", busy_lo, 1);
                uv_flag[src] = 1'b0;
                exp = 2 + tmo_cycles(s);
                count_release(0, n);
                chk(n == exp, "R4 R5 supply release time", n, exp);
            end else if (src == 4) begin
                mr_n = 1'b0;
                repeat (12) @(negedge clk);
                chk(busy_lo == 1'b1, "R2 manual reset forces reset", busy_lo, 1);
                mr_n = 1'b1;
                exp = 3 + tmo_cycles(s);
                count_release(0, n);
                chk(n == exp, "R4 R5 manual release time", n, exp);
            end else begin
                wd_ovf = 1'b1;
                @(posedge clk); #1;
                chk(busy_lo == 1'b1, "R6 watchdog starts pulse", busy_lo, 1);
                @(negedge clk); wd_ovf = 1'b0;
                exp = 1 + tmo_cycles(s);
                count_release(1, n);
                chk(n == exp, "R6 R5 watchdog pulse length", n, exp);
            end
        end

        // R3: short manual pulse ignored
        @(negedge clk); tmo_sel = 2'd0;
        repeat (5) @(negedge clk);
        mr_n = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        mr_n = 1'b1;
        stayed = 1'b1;
        repeat (15) begin
            @(negedge clk);
            if (busy_lo) stayed = 1'b0;
        end
        chk(stayed, "R3 short manual pulse rejected", int'(!stayed), 0);

        // R2: pulse of exactly FILT cycles accepted
        mr_n = 1'b0;
        repeat (FILT) @(negedge clk);
        mr_n = 1'b1;
        count_release(0, n);
        chk(n == 3 + tmo_cycles(2'd0), "R2 minimum manual pulse", n, 3 + tmo_cycles(2'd0));

        // R9: fault during countdown restarts the period
        @(negedge clk); uv_flag[0] = 1'b1;
        repeat (6) @(negedge clk);
        uv_flag[0] = 1'b0;
        repeat (100) @(posedge clk);
        #1;
        chk(busy_lo == 1'b1, "R9 still counting", busy_lo, 1);
        @(negedge clk); uv_flag[1] = 1'b1;
        @(negedge clk); uv_flag[1] = 1'b0;
        count_release(1, n);
        chk(n == 3 + tmo_cycles(2'd0), "R9 restart after glitch", n, 3 + tmo_cycles(2'd0));

        // R6: watchdog during active reset has no effect on release
        @(negedge clk); tmo_sel = 2'd1;
        repeat (5) @(negedge clk);
        uv_flag[2] = 1'b1;
        repeat (6) @(negedge clk);
        uv_flag[2] = 1'b0;
        repeat (50) @(posedge clk);
        @(negedge clk); wd_ovf = 1'b1;
        @(negedge clk); wd_ovf = 1'b0;
        count_release(51, n);
        chk(n == 2 + tmo_cycles(2'd1), "R6 watchdog ignored while active", n, 2 + tmo_cycles(2'd1));

        // R1: flag held keeps reset on
        @(negedge clk); uv_flag[3] = 1'b1;
        stayed = 1'b1;
        repeat (3) @(negedge clk);
        repeat (600) begin
            @(negedge clk);
            if (!busy_lo) stayed = 1'b0;
        end
        chk(stayed, "R1 reset held while flag high", int'(stayed), 1);
        uv_flag[3] = 1'b0;
        count_release(0, n);
        chk(n == 2 + tmo_cycles(2'd1), "R4 release after long fault", n, 2 + tmo_cycles(2'd1));

        chk(pol_bad == 0, "R7 output polarity", pol_bad, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule